// File: doc/BRIEF.md
# Two-level page table walker

This block turns a 32-bit linear address into a physical address. It reads a page directory entry and, for small pages, a page table entry from memory, one word at a time. It is used next to a translation cache. On a miss, the cache hands the walker one request: an address, a write flag and a user flag, plus snapshots of the paging control registers and the A20 address mask. The walker answers with a one-cycle `done` pulse. That pulse carries either a physical address with a write permission and a page-size flag, or a page fault with a three-bit error code. On the way it sets the accessed bit, and the dirty bit on writes, in the entries it uses. It writes an entry back only when the entry actually changed.

The request side is a valid/ready pair. `req_ready` is high only while the walker is idle. A request is taken in the cycle where `req_valid` and `req_ready` are both high. No further request is taken until the `done` pulse has been given.

The memory side is also valid/ready. While `mem_valid` is high and `mem_ready` is low, the walker holds address, write enable and write data unchanged. Read data is sampled in the cycle of the handshake. The result outputs stay plain registered signals, qualified by `done`.

Top module: `xlate_walker`

## Requirements
- R1: `req_ready` is high only in idle and drops for the cycle after a request is taken. `done` is a single-cycle pulse, and `req_ready` is high again in the cycle after it.
- R2: When control register 0 bit 31 (paging enable) is clear, no memory access occurs. The result is the linear address itself, with `writable`=1, `big_page`=0 and no fault.
- R3: The directory entry is read at ({CR3[31:12],12'h000} + 4*linear[31:22]) ANDed with the A20 mask.
- R4: For small pages, the table entry is read at ({directory entry[31:12],12'h000} + 4*linear[21:12]) ANDed with the A20 mask.
- R5: An entry with bit 0 (present) clear ends the walk with a fault whose error-code bit 0 is 0. No later entry is read.
- R6: A directory entry with bit 7 set, while control register 4 bit 4 is set, maps a 4 MB page. No table entry is read, `big_page`=1, and the result is ({entry[31:22],22'h0} AND mask) OR linear[21:0]. With control register 4 bit 4 clear, bit 7 is ignored and the entry points to a table.
- R7: For small pages, the user right (bit 2) and the write right (bit 1) are each the AND of the directory and table entry bits.
- R8: A user access without the user right faults. A user write without the write right faults. A supervisor write without the write right faults only when control register 0 bit 16 is set. These faults have error-code bit 0 = 1.
- R9: On any fault, error-code bit 1 equals the write flag and bit 2 equals the user flag.
- R10: The walker sets bit 5 (accessed) in every entry it uses, and on a write also sets bit 6 (dirty) in the final entry. For small pages the directory entry gets only bit 5. An entry is written back only if its value changed.
- R11: `writable` is 1 only if the final entry, after update, has bit 6 set and the access could write it: for a user access, the write right; for a supervisor access, the write right or control register 0 bit 16 clear.
- R12: The final frame is ANDed with the A20 mask before the page offset is added.
- R13: While `mem_valid` is high and `mem_ready` low, `mem_addr`, `mem_we` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted on handshake |
| req_addr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| cr0 | input | 32 | Control register 0 (bit 31 paging, bit 16 write protect) |
| cr3 | input | 32 | Directory base register |
| cr4 | input | 32 | Control register 4 (bit 4 large pages) |
| a20_mask | input | 32 | Mask applied to table and frame addresses |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access |
| mem_we | output | 1 | Access is a write-back |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Updated entry value |
| mem_rdata | input | 32 | Entry read data, valid on handshake |
| done | output | 1 | One-cycle result pulse |
| fault | output | 1 | Result is a page fault |
| fault_code | output | 3 | {user, write, protection} |
| phys_addr | output | 32 | Translated address |
| writable | output | 1 | Page may be written without another walk |
| big_page | output | 1 | Result is a 4 MB page |

## Verification
The bench builds the walker with its default parameters: a 12-bit page offset, two 10-bit index fields and large-page support enabled. This gives the full 32-bit entry formats, so bit 7 in a directory entry and bit 20 of the A20 mask are both reachable. The bench's memory model decodes only address bits 13:2. Directory and table pages are placed at 0x1000, 0x2000 and 0x3000, so an address that was not masked, or an entry read through an ignored large-page bit, shows up as a wrong logged address or as a fault.

// File: rtl/xw_pkg.sv
package xw_pkg;
  // entry bit positions
  localparam int E_P  = 0;
  localparam int E_RW = 1;
  localparam int E_US = 2;
  localparam int E_A  = 5;
  localparam int E_D  = 6;
  localparam int E_PS = 7;
  // control register bit positions
  localparam int C0_PG  = 31;
  localparam int C0_WP  = 16;
  localparam int C4_PSE = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_DIR,
    S_WB_DIR,
    S_RD_TBL,
    S_WB_TBL,
    S_RESP
  } walk_st_e;
endpackage

// File: rtl/xw_entry_addr.sv
module xw_entry_addr #(
  parameter int AW     = 32,
  parameter int OFFS_W = 12,
  parameter int IDX_W  = 10
) (
  input  logic [AW-1:0]    base,
  input  logic [IDX_W-1:0] idx,
  input  logic [AW-1:0]    mask,
  output logic [AW-1:0]    addr
);
  localparam int ENT_LOG = 2;
  localparam int PAD_W   = AW - IDX_W - ENT_LOG;

  logic [AW-1:0] page_base;
  logic [AW-1:0] byte_off;

  always_comb begin
    page_base = {base[AW-1:OFFS_W], {OFFS_W{1'b0}}};
    byte_off  = {{PAD_W{1'b0}}, idx, {ENT_LOG{1'b0}}};
    addr      = (page_base + byte_off) & mask;
  end
endmodule

// File: rtl/xw_perm.sv
module xw_perm (
  input  logic us_right,
  input  logic rw_right,
  input  logic dirty_after,
  input  logic is_write,
  input  logic is_user,
  input  logic wp,
  output logic prot_fault,
  output logic can_write
);
  always_comb begin
    if (is_user) begin
      prot_fault = !us_right || (is_write && !rw_right);
      can_write  = dirty_after && rw_right;
    end else begin
      prot_fault = is_write && !rw_right && wp;
      can_write  = dirty_after && (rw_right || !wp);
    end
  end
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker #(
  parameter int OFFS_W   = 12,
  parameter int IDX_W    = 10,
  parameter bit LARGE_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic        req_user,
  input  logic [31:0] cr0,
  input  logic [31:0] cr3,
  input  logic [31:0] cr4,
  input  logic [31:0] a20_mask,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic        fault,
  output logic [2:0]  fault_code,
  output logic [31:0] phys_addr,
  output logic        writable,
  output logic        big_page
);
  import xw_pkg::*;

  localparam int AW      = OFFS_W + 2 * IDX_W;
  localparam int BIG_LOW = OFFS_W + IDX_W;
  localparam logic [AW-1:0] A_BIT = AW'(1) << E_A;
  localparam logic [AW-1:0] D_BIT = AW'(1) << E_D;

  walk_st_e      st;
  logic [AW-1:0] va_q, cr3_q, a20_q, pde_q, wb_q;
  logic          wr_q, usr_q, wp_q, pse_q, big_q;
  logic [AW-1:0] r_phys;
  logic          r_fault, r_wr, r_big;
  logic [2:0]    r_code;

  logic [AW-1:0] dir_addr, tbl_addr;
  logic [AW-1:0] fin_new, dir_touched, frame, off_part, phys_c;
  logic          large_hit, sel_large, us_r, rw_r, prot_fault, can_write;

  logic unused_ctl;
  assign unused_ctl = ^{cr0, cr4};

  // entry address units
  xw_entry_addr #(.AW(AW), .OFFS_W(OFFS_W), .IDX_W(IDX_W)) u_dir_addr (
    .base(cr3_q), .idx(va_q[AW-1 -: IDX_W]), .mask(a20_q), .addr(dir_addr)
  );
  xw_entry_addr #(.AW(AW), .OFFS_W(OFFS_W), .IDX_W(IDX_W)) u_tbl_addr (
    .base(pde_q), .idx(va_q[OFFS_W +: IDX_W]), .mask(a20_q), .addr(tbl_addr)
  );

  // large page detection
  generate
    if (LARGE_EN) begin : g_big
      assign large_hit = mem_rdata[E_PS] & pse_q;
    end else begin : g_nobig
      logic unused_pse;
      assign unused_pse = pse_q;
      assign large_hit  = 1'b0;
    end
  endgenerate

  always_comb begin
    sel_large   = (st == S_RD_DIR) && large_hit;
    dir_touched = mem_rdata | A_BIT;
    fin_new     = mem_rdata | A_BIT | (wr_q ? D_BIT : '0);
    if (sel_large) begin
      us_r     = mem_rdata[E_US];
      rw_r     = mem_rdata[E_RW];
      frame    = {fin_new[AW-1:BIG_LOW], {BIG_LOW{1'b0}}};
      off_part = {{(AW-BIG_LOW){1'b0}}, va_q[BIG_LOW-1:0]};
    end else begin
      us_r     = pde_q[E_US] & mem_rdata[E_US];
      rw_r     = pde_q[E_RW] & mem_rdata[E_RW];
      frame    = {fin_new[AW-1:OFFS_W], {OFFS_W{1'b0}}};
      off_part = {{(AW-OFFS_W){1'b0}}, va_q[OFFS_W-1:0]};
    end
    phys_c = (frame & a20_q) | off_part;
  end

  xw_perm u_perm (
    .us_right   (us_r),
    .rw_right   (rw_r),
    .dirty_after(fin_new[E_D]),
    .is_write   (wr_q),
    .is_user    (usr_q),
    .wp         (wp_q),
    .prot_fault (prot_fault),
    .can_write  (can_write)
  );

  // walk sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      cr3_q   <= '0;
      a20_q   <= '0;
      pde_q   <= '0;
      wb_q    <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      wp_q    <= 1'b0;
      pse_q   <= 1'b0;
      big_q   <= 1'b0;
      r_phys  <= '0;
      r_fault <= 1'b0;
      r_wr    <= 1'b0;
      r_big   <= 1'b0;
      r_code  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            va_q  <= req_addr;
            wr_q  <= req_write;
            usr_q <= req_user;
            wp_q  <= cr0[C0_WP];
            pse_q <= cr4[C4_PSE];
            cr3_q <= cr3;
            a20_q <= a20_mask;
            if (cr0[C0_PG]) begin
              st <= S_RD_DIR;
            end else begin
              r_phys  <= req_addr;
              r_fault <= 1'b0;
              r_code  <= '0;
              r_wr    <= 1'b1;
              r_big   <= 1'b0;
              st      <= S_RESP;
            end
          end
        end
        S_RD_DIR: begin
          if (mem_ready) begin
            if (!mem_rdata[E_P]) begin
              r_fault <= 1'b1;
              r_code  <= {usr_q, wr_q, 1'b0};
              r_phys  <= '0;
              r_wr    <= 1'b0;
              r_big   <= 1'b0;
              st      <= S_RESP;
            end else if (large_hit) begin
              if (prot_fault) begin
                r_fault <= 1'b1;
                r_code  <= {usr_q, wr_q, 1'b1};
                r_phys  <= '0;
                r_wr    <= 1'b0;
                r_big   <= 1'b0;
                st      <= S_RESP;
              end else begin
                r_fault <= 1'b0;
                r_code  <= '0;
                r_phys  <= phys_c;
                r_wr    <= can_write;
                r_big   <= 1'b1;
                if (fin_new != mem_rdata) begin
                  wb_q  <= fin_new;
                  big_q <= 1'b1;
                  st    <= S_WB_DIR;
                end else begin
                  st <= S_RESP;
                end
              end
            end else begin
              pde_q <= dir_touched;
              if (!mem_rdata[E_A]) begin
                wb_q  <= dir_touched;
                big_q <= 1'b0;
                st    <= S_WB_DIR;
              end else begin
                st <= S_RD_TBL;
              end
            end
          end
        end
        S_WB_DIR: begin
          if (mem_ready) st <= big_q ? S_RESP : S_RD_TBL;
        end
        S_RD_TBL: begin
          if (mem_ready) begin
            if (!mem_rdata[E_P] || prot_fault) begin
              r_fault <= 1'b1;
              r_code  <= {usr_q, wr_q, mem_rdata[E_P]};
              r_phys  <= '0;
              r_wr    <= 1'b0;
              r_big   <= 1'b0;
              st      <= S_RESP;
            end else begin
              r_fault <= 1'b0;
              r_code  <= '0;
              r_phys  <= phys_c;
              r_wr    <= can_write;
              r_big   <= 1'b0;
              if (fin_new != mem_rdata) begin
                wb_q <= fin_new;
                st   <= S_WB_TBL;
              end else begin
                st <= S_RESP;
              end
            end
          end
        end
        S_WB_TBL: begin
          if (mem_ready) st <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // port drive
  always_comb begin
    req_ready  = (st == S_IDLE);
    mem_valid  = (st == S_RD_DIR) || (st == S_WB_DIR) || (st == S_RD_TBL) || (st == S_WB_TBL);
    mem_we     = (st == S_WB_DIR) || (st == S_WB_TBL);
    mem_addr   = ((st == S_RD_DIR) || (st == S_WB_DIR)) ? dir_addr : tbl_addr;
    mem_wdata  = wb_q;
    done       = (st == S_RESP);
    fault      = r_fault;
    fault_code = r_code;
    phys_addr  = r_phys;
    writable   = r_wr;
    big_page   = r_big;
  end
endmodule

// File: rtl/xw_checker.sv
module xw_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          req_write,
  input logic          req_user,
  input logic [AW-1:0] cr0,
  input logic [AW-1:0] a20_mask,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata,
  input logic          done,
  input logic          fault,
  input logic [2:0]    fault_code,
  input logic [AW-1:0] phys_addr,
  input logic          writable
);
  logic          busy_q, pg_l, wr_l, usr_l;
  logic [AW-1:0] va_l, a20_l;
  logic          acc;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pg_l   <= 1'b0;
      wr_l   <= 1'b0;
      usr_l  <= 1'b0;
      va_l   <= '0;
      a20_l  <= '1;
    end else if (acc) begin
      busy_q <= 1'b1;
      pg_l   <= cr0[AW-1];
      wr_l   <= req_write;
      usr_l  <= req_user;
      va_l   <= req_addr;
      a20_l  <= a20_mask;
    end else if (done) begin
      busy_q <= 1'b0;
    end
  end

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready);
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r1_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);
  a_r2_flat_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pg_l) |-> (!fault && phys_addr == va_l && writable));
  a_r2_no_memory: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !pg_l) |-> !mem_valid);
  a_r3_masked_word: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ((mem_addr & ~a20_l) == '0 && mem_addr[1:0] == 2'b00));
  a_r9_code_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (fault_code[2] == usr_l && fault_code[1] == wr_l));
  a_r10_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> (mem_wdata[5] && mem_wdata[0]));
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));
endmodule

bind xlate_walker xw_checker #(.AW(AW)) u_chk (.*);

// File: tb/test_xlate_walker.sv
module test_xlate_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0, cr0 = '0, cr3 = '0, cr4 = '0, a20_mask = '1;
  logic        mem_valid, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        done, fault, writable, big_page;
  logic [2:0]  fault_code;
  logic [31:0] phys_addr;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  xlate_walker i_xlate_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_user(req_user),
    .cr0(cr0), .cr3(cr3), .cr4(cr4), .a20_mask(a20_mask),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .fault_code(fault_code),
    .phys_addr(phys_addr), .writable(writable), .big_page(big_page)
  );

  // memory model: decodes address bits 13:2
  logic [31:0] mem [0:4095];
  int          rd_cnt, wr_cnt;
  logic [31:0] rd_log [0:3];
  logic        stall_en = 1'b0;
  logic        rdy_tgl = 1'b0;

  assign mem_rdata = mem[mem_addr[13:2]];
  assign mem_ready = stall_en ? rdy_tgl : 1'b1;

  always @(negedge clk) rdy_tgl <= ~rdy_tgl;

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_log[rd_cnt[1:0]] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  logic [31:0] o_phys;
  logic        o_fault, o_wr, o_big;
  logic [2:0]  o_code;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] v);
    @(negedge clk);
    mem[a[13:2]] <= v;
  endtask

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem[a[13:2]];
  endfunction

  task automatic walk(input logic [31:0] a, input logic w, input logic u);
    int n;
    @(negedge clk);
    rd_cnt    <= 0;
    wr_cnt    <= 0;
    req_addr  <= a;
    req_write <= w;
    req_user  <= u;
    req_valid <= 1'b1;
    @(negedge clk);
    req_valid <= 1'b0;
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk("R1 done timeout", 32'd0, 32'd1);
    o_phys  = phys_addr;
    o_fault = fault;
    o_wr    = writable;
    o_big   = big_page;
    o_code  = fault_code;
  endtask

  task automatic t_reset;
    chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R1 done low after reset", {31'd0, done}, 32'd0);
    chk("R13 no memory access after reset", {31'd0, mem_valid}, 32'd0);
  endtask

  task automatic t_no_paging;
    cr0 = 32'h0000_0000;
    walk(32'h1234_5678, 1'b1, 1'b1);
    chk("R2 flat address", o_phys, 32'h1234_5678);
    chk("R2 flat writable", {31'd0, o_wr}, 32'd1);
    chk("R2 no fault", {31'd0, o_fault}, 32'd0);
    chk("R2 no reads", rd_cnt, 0);
    @(negedge clk);
    chk("R1 ready after done", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_small_read;
    cr0 = 32'h8000_0000;
    poke(32'h1004, 32'h0000_2007);
    poke(32'h200C, 32'h0055_5007);
    walk(32'h0040_3ABC, 1'b0, 1'b0);
    chk("R3 directory entry address", rd_log[0], 32'h1004);
    chk("R4 table entry address", rd_log[1], 32'h200C);
    chk("R4 small phys", o_phys, 32'h0055_5ABC);
    chk("R11 clean read maps read-only", {31'd0, o_wr}, 32'd0);
    chk("R10 two write-backs", wr_cnt, 2);
    chk("R10 directory gets accessed only", peek(32'h1004), 32'h0000_2027);
    chk("R10 table gets accessed", peek(32'h200C), 32'h0055_5027);
    walk(32'h0040_3ABC, 1'b0, 1'b0);
    chk("R10 unchanged entries not written", wr_cnt, 0);
  endtask

  task automatic t_small_write;
    walk(32'h0040_3ABC, 1'b1, 1'b1);
    chk("R10 write sets dirty in table", peek(32'h200C), 32'h0055_5067);
    chk("R10 directory not dirtied", peek(32'h1004), 32'h0000_2027);
    chk("R10 one write-back", wr_cnt, 1);
    chk("R11 write maps writable", {31'd0, o_wr}, 32'd1);
    walk(32'h0040_3ABC, 1'b0, 1'b1);
    chk("R11 dirty read maps writable", {31'd0, o_wr}, 32'd1);
    chk("R11 dirty read no fault", {31'd0, o_fault}, 32'd0);
  endtask

  task automatic t_not_present;
    poke(32'h1008, 32'h0000_0000);
    walk(32'h0080_0000, 1'b1, 1'b0);
    chk("R5 directory not present fault", {31'd0, o_fault}, 32'd1);
    chk("R9 code sup write not present", {29'd0, o_code}, 32'd2);
    chk("R5 no table read", rd_cnt, 1);
    poke(32'h100C, 32'h0000_2027);
    poke(32'h2014, 32'h0000_0000);
    walk(32'h00C0_5000, 1'b0, 1'b1);
    chk("R5 table not present fault", {31'd0, o_fault}, 32'd1);
    chk("R9 code user read not present", {29'd0, o_code}, 32'd4);
  endtask

  task automatic t_rights;
    poke(32'h1010, 32'h0000_3023);
    poke(32'h3000, 32'h0077_7067);
    walk(32'h0100_0000, 1'b0, 1'b1);
    chk("R7 directory user bit clears right", {31'd0, o_fault}, 32'd1);
    chk("R8 user protection code", {29'd0, o_code}, 32'd5);
    walk(32'h0100_0000, 1'b0, 1'b0);
    chk("R8 supervisor read allowed", {31'd0, o_fault}, 32'd0);
    chk("R8 supervisor phys", o_phys, 32'h0077_7000);
  endtask

  task automatic t_wp;
    poke(32'h1014, 32'h0000_3025);
    poke(32'h3004, 32'h0088_8067);
    cr0 = 32'h8000_0000;
    walk(32'h0140_1234, 1'b1, 1'b0);
    chk("R8 sup write to ro without WP ok", {31'd0, o_fault}, 32'd0);
    chk("R7 phys via combined rights", o_phys, 32'h0088_8234);
    chk("R11 sup without WP writable", {31'd0, o_wr}, 32'd1);
    chk("R10 no change no write-back", wr_cnt, 0);
    cr0 = 32'h8001_0000;
    walk(32'h0140_1234, 1'b1, 1'b0);
    chk("R8 sup write to ro with WP faults", {31'd0, o_fault}, 32'd1);
    chk("R9 code sup write protection", {29'd0, o_code}, 32'd3);
    walk(32'h0140_1234, 1'b1, 1'b1);
    chk("R8 user write to ro faults", {29'd0, o_code}, 32'd7);
    cr0 = 32'h8000_0000;
  endtask

  task automatic t_large;
    cr4 = 32'h0000_0010;
    poke(32'h1018, 32'h0AC5_5087);
    walk(32'h0187_6543, 1'b1, 1'b1);
    chk("R6 large phys", o_phys, 32'h0AC7_6543);
    chk("R6 big page flag", {31'd0, o_big}, 32'd1);
    chk("R6 single read", rd_cnt, 1);
    chk("R10 large entry dirtied", peek(32'h1018), 32'h0AC5_50E7);
    chk("R11 large writable", {31'd0, o_wr}, 32'd1);
    cr4 = 32'h0000_0000;
    walk(32'h0187_6543, 1'b1, 1'b1);
    chk("R6 size bit ignored without enable", rd_log[1], 32'h0AC5_51D8);
    chk("R6 ignored size bit table fault", {29'd0, o_code}, 32'd6);
  endtask

  task automatic t_a20;
    cr3      = 32'h0010_1000;
    a20_mask = 32'hFFEF_FFFF;
    poke(32'h101C, 32'h0000_2027);
    poke(32'h2018, 32'h0015_6067);
    walk(32'h01C0_6123, 1'b0, 1'b0);
    chk("R3 directory address masked", rd_log[0], 32'h0000_101C);
    chk("R4 table address", rd_log[1], 32'h0000_2018);
    chk("R12 frame masked", o_phys, 32'h0005_6123);
    cr3      = 32'h0000_1000;
    a20_mask = 32'hFFFF_FFFF;
  endtask

  task automatic t_stall;
    stall_en = 1'b1;
    poke(32'h1024, 32'h0000_3007);
    poke(32'h3008, 32'h0099_9005);
    walk(32'h0240_2FFF, 1'b0, 1'b1);
    chk("R13 stalled phys", o_phys, 32'h0099_9FFF);
    chk("R13 stalled reads", rd_cnt, 2);
    chk("R13 stalled writes", wr_cnt, 2);
    chk("R10 stalled directory", peek(32'h1024), 32'h0000_3027);
    chk("R10 stalled table", peek(32'h3008), 32'h0099_9025);
    chk("R11 stalled read-only", {31'd0, o_wr}, 32'd0);
    stall_en = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    rd_cnt = 0;
    wr_cnt = 0;
    cr3 = 32'h0000_1000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_no_paging;
    t_small_read;
    t_small_write;
    t_not_present;
    t_rights;
    t_wp;
    t_large;
    t_a20;
    t_stall;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule